// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block produces the active-low system reset for a processor subsystem. It watches two digital health flags, one for the main supply and one for an auxiliary sense voltage, together with an active-low manual reset request. Whenever any of these shows a fault, reset is driven low. Once every fault has gone away, reset is held for a further stretch period before it is released. The flags are expected to arrive already compared against their thresholds, with hysteresis applied, and synchronous to the block clock.

A watchdog runs while reset is released. Software keeps it quiet by toggling the kick input, and a change of level in either direction counts as a kick. If the time since the last accepted kick reaches the timeout, the block issues one reset pulse of exactly the stretch length. A status output reports whether the reset in progress came from a watchdog expiry. All timing advances on a slow tick-enable strobe. The stretch period, the timeout and the minimum kick width are tick-count parameters. The manual request and the kick input are asynchronous, and each passes through a two-flop synchroniser.

Top module: `rst_supervisor`

## Requirements
- R1: `sys_rst_n` is 0 whenever `supply_ok` is 0, `sense_ok` is 0 or the synchronised `mrst_n` is 0. An input tied high at `mrst_n` causes no reset.
- R2: After the last active condition clears, `sys_rst_n` stays 0 for exactly `TD_TICKS` ticks and then goes to 1. The `mrst_n` path may add at most one tick for its synchroniser.
- R3: If a condition reappears during the stretch, reset stays 0 and the full `TD_TICKS` count starts again from the moment it clears.
- R4: With reset released and no accepted kick, `sys_rst_n` falls after exactly `WD_TICKS` ticks.
- R5: A rising and a falling level change on `wd_kick` are both accepted as kicks, and each restarts the timeout. An accepted kick comes `MIN_KICK_TICKS` to `MIN_KICK_TICKS`+1 ticks after the change.
- R6: A watchdog reset pulse lasts exactly `TD_TICKS` ticks when no other condition is active.
- R7: The watchdog count stays cleared while reset is asserted, however long reset lasts. After release, the timeout runs a full `WD_TICKS`.
- R8: A level change on `wd_kick` that does not hold for `MIN_KICK_TICKS` ticks is ignored and does not delay expiry.
- R9: While `arst_n` is 0, `sys_rst_n` is 0. After power-on the stretch begins only when all conditions are inactive.
- R10: `rst_by_wdog` is 1 only during a reset that began with a watchdog expiry. It stays 1 until that reset releases, even if a condition arrives in the meantime. It is 0 for condition-caused resets and whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_en | input | 1 | Timebase strobe; one tick per high cycle |
| supply_ok | input | 1 | 1 when the main supply is above its threshold |
| sense_ok | input | 1 | 1 when the auxiliary sense voltage is above its reference |
| mrst_n | input | 1 | Manual reset request, active low, asynchronous |
| wd_kick | input | 1 | Watchdog service input; either level change is a kick |
| sys_rst_n | output | 1 | System reset, active low |
| rst_by_wdog | output | 1 | 1 during a reset caused by watchdog expiry |

## Verification
On every cycle, the checker enforces the following:
- Any active condition pulls reset low on the next edge.
- A release happens only on a tick while no condition is active.
- The watchdog count is zero throughout a held reset.
- An expiry lands in a watchdog-caused reset.
- The cause flag never shows while reset is released.
- An accepted kick lasts a single cycle.

The exact lengths can only be shown by the bench scenarios, which measure tick counts between observed edges. These are the stretch after each kind of release, its restart, the expiry interval, the pulse width, the tolerance to short glitches and the keep-alive by alternating kicks.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic {
    CAUSE_COND = 1'b0,
    CAUSE_WDOG = 1'b1
  } cause_e;

  // width for a counter that must hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

  // true when a count has reached the last step of an n-tick interval
  function automatic logic at_last(input int unsigned cnt, input int unsigned n);
    return cnt == (n - 1);
  endfunction

endpackage

// File: rtl/rsv_sync2.sv
module rsv_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rsv_kick_filter.sv
module rsv_kick_filter #(
  parameter int MIN_KICK_TICKS = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_en,
  input  logic lvl_in,
  output logic kick
);
  import rsv_pkg::*;
  localparam int MK_W = cnt_width(MIN_KICK_TICKS);

  logic            lvl_q;
  logic [MK_W-1:0] hold_cnt;
  logic            differs;

  assign differs = lvl_in != lvl_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lvl_q    <= 1'b0;
      hold_cnt <= '0;
      kick     <= 1'b0;
    end else begin
      kick <= 1'b0;
      if (!differs) begin
        hold_cnt <= '0;
      end else if (tick_en) begin
        if (at_last(int'(hold_cnt), MIN_KICK_TICKS)) begin
          lvl_q    <= lvl_in;
          hold_cnt <= '0;
          kick     <= 1'b1;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsv_wdog_timer.sv
module rsv_wdog_timer #(
  parameter int WD_TICKS = 1100
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_en,
  input  logic hold,
  input  logic kick,
  output logic expire,
  output logic at_zero
);
  import rsv_pkg::*;
  localparam int WD_W = cnt_width(WD_TICKS);

  logic [WD_W-1:0] wd_cnt;

  assign expire  = !hold && !kick && tick_en && at_last(int'(wd_cnt), WD_TICKS);
  assign at_zero = wd_cnt == '0;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wd_cnt <= '0;
    end else if (hold || kick || expire) begin
      wd_cnt <= '0;
    end else if (tick_en) begin
      wd_cnt <= wd_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch #(
  parameter int TD_TICKS = 130
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            tick_en,
  input  logic            fault,
  input  logic            wd_expire,
  output logic            rst_q,
  output rsv_pkg::cause_e cause
);
  import rsv_pkg::*;
  localparam int TD_W = cnt_width(TD_TICKS);

  logic [TD_W-1:0] td_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_q  <= 1'b1;
      td_cnt <= '0;
      cause  <= CAUSE_COND;
    end else if (fault) begin
      rst_q  <= 1'b1;
      td_cnt <= '0;
      if (!rst_q) cause <= CAUSE_COND;
    end else if (wd_expire) begin
      rst_q  <= 1'b1;
      td_cnt <= '0;
      cause  <= CAUSE_WDOG;
    end else if (rst_q && tick_en) begin
      if (at_last(int'(td_cnt), TD_TICKS)) begin
        rst_q  <= 1'b0;
        td_cnt <= '0;
      end else begin
        td_cnt <= td_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int TD_TICKS       = 130,
  parameter int WD_TICKS       = 1100,
  parameter int MIN_KICK_TICKS = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_en,
  input  logic supply_ok,
  input  logic sense_ok,
  input  logic mrst_n,
  input  logic wd_kick,
  output logic sys_rst_n,
  output logic rst_by_wdog
);
  import rsv_pkg::*;

  logic   mrst_s, kick_s;
  logic   fault_now, kick_pulse, wd_expire, wd_at_zero, rst_q;
  cause_e cause;

  rsv_sync2 #(.RST_VAL(1'b1)) u_sync_mr (
    .clk(clk), .arst_n(arst_n), .d(mrst_n), .q(mrst_s)
  );

  rsv_sync2 #(.RST_VAL(1'b0)) u_sync_kick (
    .clk(clk), .arst_n(arst_n), .d(wd_kick), .q(kick_s)
  );

  rsv_kick_filter #(.MIN_KICK_TICKS(MIN_KICK_TICKS)) u_kick (
    .clk(clk), .arst_n(arst_n), .tick_en(tick_en),
    .lvl_in(kick_s), .kick(kick_pulse)
  );

  assign fault_now = !supply_ok || !sense_ok || !mrst_s;

  rsv_wdog_timer #(.WD_TICKS(WD_TICKS)) u_wdog (
    .clk(clk), .arst_n(arst_n), .tick_en(tick_en), .hold(rst_q),
    .kick(kick_pulse), .expire(wd_expire), .at_zero(wd_at_zero)
  );

  rsv_stretch #(.TD_TICKS(TD_TICKS)) u_stretch (
    .clk(clk), .arst_n(arst_n), .tick_en(tick_en), .fault(fault_now),
    .wd_expire(wd_expire), .rst_q(rst_q), .cause(cause)
  );

  assign sys_rst_n   = !rst_q;
  assign rst_by_wdog = rst_q && (cause == CAUSE_WDOG);
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk (
  input logic clk,
  input logic arst_n,
  input logic tick_en,
  input logic fault_now,
  input logic kick_pulse,
  input logic wd_expire,
  input logic wd_at_zero,
  input logic sys_rst_n,
  input logic rst_by_wdog
);
  AST_FAULT_FORCES_RST: assert property (@(posedge clk) disable iff (!arst_n)
    fault_now |=> !sys_rst_n); // R1

  AST_RELEASE_ON_CLEAN_TICK: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n) |-> ($past(tick_en) && !$past(fault_now))); // R2

  AST_EXPIRE_GIVES_WDOG_RST: assert property (@(posedge clk) disable iff (!arst_n)
    (wd_expire && !fault_now) |=> (!sys_rst_n && rst_by_wdog)); // R4

  AST_KICK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
    kick_pulse |=> !kick_pulse); // R5

  AST_WDOG_HELD_IN_RST: assert property (@(posedge clk) disable iff (!arst_n)
    (!sys_rst_n && $past(!sys_rst_n)) |-> wd_at_zero); // R7

  AST_CAUSE_ONLY_IN_RST: assert property (@(posedge clk) disable iff (!arst_n)
    rst_by_wdog |-> !sys_rst_n); // R10
endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
  .clk(clk), .arst_n(arst_n), .tick_en(tick_en), .fault_now(fault_now),
  .kick_pulse(kick_pulse), .wd_expire(wd_expire), .wd_at_zero(wd_at_zero),
  .sys_rst_n(sys_rst_n), .rst_by_wdog(rst_by_wdog)
);

// File: tb/rst_supervisor_tb.sv
`timescale 1ns/1ps
module rst_supervisor_tb;
  localparam int TD = 5;
  localparam int WD = 12;
  localparam int MK = 2;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic tick_en = 1'b0;
  logic supply_ok = 1'b0;
  logic sense_ok = 1'b1;
  logic mrst_n = 1'b1;
  logic wd_kick = 1'b0;
  logic sys_rst_n, rst_by_wdog;

  int checks = 0;
  int failures = 0;
  int tick_seen = 0;
  int rise_cnt = 0, fall_cnt = 0, rise_tick = 0, fall_tick = 0;
  int t_clear = 0;
  logic prev_rst_n = 1'b0;

  always #2.5 clk = ~clk;

  rst_supervisor #(.TD_TICKS(TD), .WD_TICKS(WD), .MIN_KICK_TICKS(MK)) u_dut (
    .clk(clk), .arst_n(arst_n), .tick_en(tick_en), .supply_ok(supply_ok),
    .sense_ok(sense_ok), .mrst_n(mrst_n), .wd_kick(wd_kick),
    .sys_rst_n(sys_rst_n), .rst_by_wdog(rst_by_wdog)
  );

  // one tick every fourth cycle
  initial forever begin
    repeat (3) @(negedge clk) tick_en = 1'b0;
    @(negedge clk) tick_en = 1'b1;
  end

  always @(posedge clk) if (arst_n && tick_en) tick_seen <= tick_seen + 1;

  always @(negedge clk) begin
    if (sys_rst_n && !prev_rst_n) begin rise_cnt++; rise_tick = tick_seen; end
    if (!sys_rst_n && prev_rst_n) begin fall_cnt++; fall_tick = tick_seen; end
    prev_rst_n = sys_rst_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int start = tick_seen;
    while (tick_seen - start < n) @(negedge clk);
  endtask

  task automatic wait_rise(input string req);
    int n0 = rise_cnt;
    int start = tick_seen;
    while (rise_cnt == n0 && tick_seen - start < 200) @(negedge clk);
    if (rise_cnt == n0) check(1'b0, req, 0, 1);
  endtask

  task automatic wait_fall(input string req);
    int n0 = fall_cnt;
    int start = tick_seen;
    while (fall_cnt == n0 && tick_seen - start < 200) @(negedge clk);
    if (fall_cnt == n0) check(1'b0, req, 0, 1);
  endtask

  initial begin
    int n_fall;
    int d;
    int t_last;
    repeat (5) @(negedge clk);
    // R9: held in reset during power-on reset
    check(sys_rst_n == 1'b0, "R9", sys_rst_n, 0);
    check(rst_by_wdog == 1'b0, "R10", rst_by_wdog, 0);
    arst_n = 1'b1;
    wait_ticks(3 * TD);
    // R1 R9: supply still low keeps reset asserted
    check(sys_rst_n == 1'b0, "R1", sys_rst_n, 0);
    supply_ok = 1'b1;
    t_clear = tick_seen;
    wait_rise("R9");
    check(rise_tick - t_clear == TD, "R2", rise_tick - t_clear, TD);

    // R4 expiry, R6 pulse width, R10 cause
    wait_fall("R4");
    check(fall_tick - rise_tick == WD, "R4", fall_tick - rise_tick, WD);
    @(negedge clk);
    check(rst_by_wdog == 1'b1, "R10", rst_by_wdog, 1);
    wait_rise("R6");
    check(rise_tick - fall_tick == TD, "R6", rise_tick - fall_tick, TD);
    check(rst_by_wdog == 1'b0, "R10", rst_by_wdog, 0);

    // R8: short glitches on the kick input are ignored
    n_fall = fall_cnt;
    while (fall_cnt == n_fall) begin
      @(negedge clk) wd_kick = ~wd_kick;
      repeat (4) @(negedge clk);
      wd_kick = ~wd_kick;
      wait_ticks(2);
    end
    check(fall_tick - rise_tick == WD, "R8", fall_tick - rise_tick, WD);

    // R10: a condition during a watchdog pulse keeps the cause
    @(negedge clk) sense_ok = 1'b0;
    wait_ticks(2);
    check(rst_by_wdog == 1'b1, "R10", rst_by_wdog, 1);
    sense_ok = 1'b1;
    t_clear = tick_seen;
    wait_rise("R2");
    check(rise_tick - t_clear == TD, "R2", rise_tick - t_clear, TD);

    // R3: a condition during the stretch restarts it
    @(negedge clk) supply_ok = 1'b0;
    wait_ticks(1);
    check(sys_rst_n == 1'b0 && rst_by_wdog == 1'b0, "R1", {sys_rst_n, rst_by_wdog}, 0);
    supply_ok = 1'b1;
    wait_ticks(TD - 2);
    check(sys_rst_n == 1'b0, "R3", sys_rst_n, 0);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    t_clear = tick_seen;
    wait_rise("R3");
    check(rise_tick - t_clear == TD, "R3", rise_tick - t_clear, TD);

    // R5: alternating kicks keep reset released
    n_fall = fall_cnt;
    for (int k = 0; k < 8; k++) begin
      wait_ticks(5);
      wd_kick = ~wd_kick;
    end
    t_last = tick_seen;
    check(fall_cnt == n_fall, "R5", fall_cnt - n_fall, 0);
    wait_fall("R5");
    d = fall_tick - t_last;
    check(d >= WD + MK && d <= WD + MK + 1, "R5", d, WD + MK);
    wait_rise("R6");

    // R7: long reset does not advance the watchdog
    @(negedge clk) supply_ok = 1'b0;
    wait_ticks(3 * WD);
    supply_ok = 1'b1;
    t_clear = tick_seen;
    wait_rise("R7");
    check(rise_tick - t_clear == TD, "R2", rise_tick - t_clear, TD);
    wait_fall("R7");
    check(fall_tick - rise_tick == WD, "R7", fall_tick - rise_tick, WD);
    wait_rise("R6");

    // R1: manual request through its synchroniser
    @(negedge clk) mrst_n = 1'b0;
    wait_ticks(2);
    check(sys_rst_n == 1'b0 && rst_by_wdog == 1'b0, "R1", {sys_rst_n, rst_by_wdog}, 0);
    mrst_n = 1'b1;
    t_clear = tick_seen;
    wait_rise("R2");
    d = rise_tick - t_clear;
    check(d >= TD && d <= TD + 1, "R2", d, TD);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule